// File: doc/BRIEF.md
# Nth Set Bit Locator

This unit finds the bit position of the n-th set bit in a 64-bit lane mask, counted from a chosen base position. A positive count searches toward the most significant end, a negative count searches toward the least significant end, and a count of zero asks only whether the base bit itself is set. When the requested bit does not exist, the unit returns -1.

The search does not use a priority encoder. It narrows the mask by repeated halving. At each level, a population count of the low window decides which half holds the target bit. The accumulated window sizes give the position. A downward search runs on the bit-reversed mask with a mirrored base, and the position found is mirrored back.

The whole search is combinational and finishes in one registered cycle. A request with `in_valid` high produces a result with `out_valid` high on the next clock edge. There is no state machine. The direction is the only mode, an enumeration with three values:
- `DIR_SELF`: the offset is zero.
- `DIR_UP`: the offset is positive.
- `DIR_DOWN`: the offset is negative.

Top module: `nth_bit_locate`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_pos` is 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. In a cycle that follows an idle input cycle, `out_pos` keeps its previous value.
- R3: For a positive offset k, `out_pos` is the position of the k-th set bit found when scanning from `in_base` upward to bit 63. The base bit counts as the first bit scanned.
- R4: For offset 0, `out_pos` equals `in_base` if `in_mask[in_base]` is 1, and -1 otherwise. This holds for every base from 0 to 63.
- R5: For a negative offset -k, `out_pos` is the position of the k-th set bit found when scanning from `in_base` downward to bit 0. The base bit counts as the first bit scanned.
- R6: When fewer set bits lie in the scanned range than the magnitude of the offset, `out_pos` is -1, which is all 32 bits set.
- R7: An all-zero mask yields -1 for every base and offset.
- R8: Bases 0 and 63 are handled in both directions. With an all-ones mask and offset ±64, the result is the far end of the mask only when the scan starts at the opposite end.
- R9: Whenever `out_valid` is 1, `out_pos` is either -1 or a value from 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The request on the other inputs is valid |
| in_mask | input | 64 | Lane mask to search |
| in_base | input | 6 | Starting bit position |
| in_offset | input | 8 | Signed count, -64 to 64; its sign selects the direction |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_pos | output | 32 | Signed position of the bit found, or -1 |

## Verification
The bench builds the block with its default widths: a 64-bit mask, giving six halving levels, and an 8-bit offset. These defaults make every window size from 32 down to 1 reachable. They also cover offsets of ±64, which need every bit of the mask, and zero-offset tests on bases from 32 to 63, where a narrow base-bit mask would fail. Random masks of three densities (dense, typical and sparse) exercise both outcomes of the comparison at each halving level, in both directions.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
    typedef enum logic [1:0] {
        DIR_SELF = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;
endpackage

// File: rtl/nbl_prep.sv
module nbl_prep
    import nbl_pkg::*;
#(
    parameter int MASK_W = 64,
    parameter int OFF_W  = 8,
    localparam int POS_W = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0]       mask_i,
    input  logic [POS_W-1:0]        base_i,
    input  logic signed [OFF_W-1:0] off_i,
    output dir_e                    dir_o,
    output logic [MASK_W-1:0]       mask_o,
    output logic [OFF_W-1:0]        need_o
);
    logic [MASK_W-1:0] rev;
    logic [POS_W-1:0]  mbase;

    always_comb begin
        for (int i = 0; i < MASK_W; i++) rev[i] = mask_i[MASK_W-1-i];
    end

    always_comb begin
        if (off_i == '0)      dir_o = DIR_SELF;
        else if (off_i[OFF_W-1]) dir_o = DIR_DOWN;
        else                  dir_o = DIR_UP;
    end

    always_comb begin
        mbase  = base_i;
        mask_o = '0;
        need_o = '0;
        unique case (dir_o)
            DIR_SELF: begin
                // full-width one-hot so high bases survive
                mask_o = mask_i & (MASK_W'(1) << base_i);
                need_o = OFF_W'(1);
            end
            DIR_UP: begin
                mask_o = mask_i & ({MASK_W{1'b1}} << base_i);
                need_o = off_i;
            end
            DIR_DOWN: begin
                mbase  = POS_W'(MASK_W-1) - base_i;
                mask_o = rev & ({MASK_W{1'b1}} << mbase);
                need_o = -off_i;
            end
            default: begin
                mask_o = '0;
                need_o = '0;
            end
        endcase
    end

    always_comb begin
        a_self_onehot_r4: assert (dir_o != DIR_SELF || $countones(mask_o) <= 1);
    end
endmodule

// File: rtl/nbl_halve.sv
module nbl_halve #(
    parameter int MASK_W = 64,
    parameter int NEED_W = 8,
    parameter int WIN    = 32,
    localparam int POS_W = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0] m_i,
    input  logic [NEED_W-1:0] need_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic [MASK_W-1:0] m_o,
    output logic [NEED_W-1:0] need_o,
    output logic [POS_W-1:0]  pos_o
);
    localparam logic [MASK_W-1:0] LO_MASK = (MASK_W'(1) << WIN) - MASK_W'(1);

    logic [MASK_W-1:0] lo;
    logic [NEED_W-1:0] lo_cnt;

    always_comb begin
        lo     = m_i & LO_MASK;
        lo_cnt = '0;
        for (int i = 0; i < WIN; i++) lo_cnt = lo_cnt + NEED_W'(lo[i]);
    end

    always_comb begin
        if (lo_cnt < need_i) begin
            m_o    = m_i >> WIN;
            need_o = need_i - lo_cnt;
            pos_o  = pos_i + POS_W'(WIN);
        end else begin
            m_o    = lo;
            need_o = need_i;
            pos_o  = pos_i;
        end
    end
endmodule

// File: rtl/nth_bit_locate.sv
module nth_bit_locate
    import nbl_pkg::*;
#(
    parameter int MASK_W = 64,
    parameter int OFF_W  = 8,
    parameter int RES_W  = 32,
    localparam int POS_W = $clog2(MASK_W),
    localparam int CNT_W = POS_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [MASK_W-1:0]       in_mask,
    input  logic [POS_W-1:0]        in_base,
    input  logic signed [OFF_W-1:0] in_offset,
    output logic                    out_valid,
    output logic signed [RES_W-1:0] out_pos
);
    dir_e              dir;
    logic [MASK_W-1:0] pmask;
    logic [OFF_W-1:0]  need;
    logic [CNT_W-1:0]  total;
    logic              found;
    logic [POS_W-1:0]  fin_pos;
    logic signed [RES_W-1:0] res_d;

    logic [MASK_W-1:0] m_c [POS_W+1];
    logic [OFF_W-1:0]  n_c [POS_W+1];
    logic [POS_W-1:0]  p_c [POS_W+1];

    nbl_prep #(.MASK_W(MASK_W), .OFF_W(OFF_W)) u_prep (
        .mask_i (in_mask),
        .base_i (in_base),
        .off_i  (in_offset),
        .dir_o  (dir),
        .mask_o (pmask),
        .need_o (need)
    );

    assign m_c[0] = pmask;
    assign n_c[0] = need;
    assign p_c[0] = '0;

    for (genvar k = 0; k < POS_W; k++) begin : g_level
        nbl_halve #(.MASK_W(MASK_W), .NEED_W(OFF_W), .WIN(MASK_W >> (k+1))) u_halve (
            .m_i    (m_c[k]),
            .need_i (n_c[k]),
            .pos_i  (p_c[k]),
            .m_o    (m_c[k+1]),
            .need_o (n_c[k+1]),
            .pos_o  (p_c[k+1])
        );
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < MASK_W; i++) total = total + CNT_W'(pmask[i]);
        found   = (OFF_W'(total) >= need) && (need != '0);
        fin_pos = (dir == DIR_DOWN) ? POS_W'(MASK_W-1) - p_c[POS_W] : p_c[POS_W];
        res_d   = found ? RES_W'(fin_pos) : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pos   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_pos <= res_d;
        end
    end

    p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_pos)));
    p_self_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_offset == '0 && in_mask[in_base]) |=> out_pos == RES_W'($past(in_base)));
    p_self_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_offset == '0 && !in_mask[in_base]) |=> out_pos == -1);
    p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mask == '0) |=> out_pos == -1);
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pos == -1 || (out_pos >= 0 && out_pos < MASK_W)));
endmodule

// File: tb/test_nth_bit_locate.sv
`timescale 1ns/1ps
module test_nth_bit_locate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_mask = '0;
    logic [5:0]  in_base = '0;
    logic signed [7:0]  in_offset = '0;
    logic        out_valid;
    logic signed [31:0] out_pos;

    typedef struct {
        bit    vld;
        int    pos;
        string tag;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    int last_pos = 0;

    always #2 clk = ~clk;

    nth_bit_locate i_nth_bit_locate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask),
        .in_base(in_base), .in_offset(in_offset),
        .out_valid(out_valid), .out_pos(out_pos)
    );

    function automatic int scan(logic [63:0] m, int b, int off);
        int c = 0;
        if (off == 0) return m[b] ? b : -1;
        if (off > 0) begin
            for (int i = b; i < 64; i++) if (m[i]) begin c++; if (c == off) return i; end
        end else begin
            for (int i = b; i >= 0; i--) if (m[i]) begin c++; if (c == -off) return i; end
        end
        return -1;
    endfunction

    task automatic drive(logic [63:0] m, int b, int off, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_mask = m; in_base = 6'(b); in_offset = 8'(off);
        q.push_back('{1'b1, scan(m, b, off), tag});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_mask = {$urandom, $urandom}; in_offset = 8'sd5;
            q.push_back('{1'b0, 0, "R2"});
        end
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk); #1;
            if (rst_n && q.size() > 0) begin
                it = q.pop_front();
                n_vec++;
                if (it.vld) begin
                    if (out_valid !== 1'b1 || out_pos !== it.pos) begin
                        n_bad++;
                        $display("FAIL %s: valid=%0b pos=%0d expected valid=1 pos=%0d",
                                 it.tag, out_valid, out_pos, it.pos);
                    end
                    last_pos = it.pos;
                end else if (out_valid !== 1'b0 || out_pos !== last_pos) begin
                    n_bad++;
                    $display("FAIL R2: idle valid=%0b pos=%0d expected valid=0 pos=%0d",
                             out_valid, out_pos, last_pos);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        int b, off, sel;
        logic [63:0] m;
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (out_valid !== 1'b0 || out_pos !== 0) begin   // R1 reset state
            n_bad++;
            $display("FAIL R1: valid=%0b pos=%0d expected valid=0 pos=0", out_valid, out_pos);
        end
        @(negedge clk); rst_n = 1'b1;

        drive(64'h0000_0000_0000_00F0, 0, 2, "R3");
        drive(64'h8000_0000_0000_0001, 1, 1, "R3");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 10, 54, "R3");
        idle(2);
        drive(64'h8000_0000_0000_0000, 63, 0, "R4");
        drive(64'h7FFF_FFFF_FFFF_FFFF, 63, 0, "R4");
        drive(64'h0000_0001_0000_0000, 32, 0, "R4");
        drive(64'h0000_0000_0000_0001, 0, 0, "R4");
        drive(64'h0000_0000_0000_0F00, 63, -3, "R5");
        drive(64'h0000_0000_0000_0001, 63, -1, "R5");
        drive(64'h0000_0000_0000_0003, 5, 3, "R6");
        drive(64'hF000_0000_0000_0000, 62, -4, "R6");
        for (int o = -64; o <= 64; o += 16) drive(64'h0, 31, o, "R7");
        drive(64'h0, 0, 0, "R7");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 0, 64, "R8");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 63, -64, "R8");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 1, 64, "R8");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 62, -64, "R8");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 63, 1, "R8");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 0, -1, "R8");
        for (int bb = 0; bb < 64; bb++) drive(64'hA5A5_5A5A_C3C3_3C3C, bb, 0, "R4");

        for (int n = 0; n < 3000; n++) begin
            sel = $urandom_range(0, 2);
            m = {$urandom, $urandom};
            if (sel == 1) m = m & {$urandom, $urandom} & {$urandom, $urandom};
            if (sel == 2) m = m | {$urandom, $urandom};
            b = $urandom_range(0, 63);
            off = $urandom_range(0, 128) - 64;
            if ($urandom_range(0, 7) == 0) off = $urandom_range(0, 8) - 4;
            drive(m, b, off, off > 0 ? "R3" : (off < 0 ? "R5" : "R4"));
            if ($urandom_range(0, 9) == 0) idle(1);
        end
        idle(1);
        wait (q.size() == 0);
        @(posedge clk); #1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule